// File: doc/BRIEF.md
# Per-Class RSS Queue Redirector

This block picks the receive queue for an incoming packet from two inputs: its traffic class and the low bits of its receive-side-scaling hash. Software loads one shared indirection table that gives a queue number local to a class. Each write to that table fans out to every active class. Each class keeps its own redirection table, and the value stored there is the local queue number shifted by that class's queue offset (class index times queues per class).

A lookup request carries a class and a hash. One clock later the block returns the final queue number. A class that is not active returns queue 0 and raises an error flag. The block also drives a control word for neighbouring logic. In that word, one select bit turns on the secondary-table mode whenever more than four classes are active.

Top module: `rss_tc_redirector`

## Requirements
- R1: A lookup of class c returns (c * q_per_tc + v) modulo 32, where v is the local queue last written to the same entry while class c was active and q_per_tc is the value present at that write.
- R2: A write to entry i updates entry i in every class below the active count in the same cycle. Tables of classes at or above the active count keep their earlier contents.
- R3: A lookup indexes its class table with bits [5:0] of the hash. Hash bits above bit 5 have no effect on the result.
- R4: res_valid equals lk_valid of the previous cycle. The result of a request appears on the outputs exactly one clock after the request.
- R5: A valid lookup whose class is at or above the active count returns queue 0 with res_err at 1. A lookup of an active class returns res_err at 0.
- R6: Bit 12 of redir_ctrl is 1 in the cycle after the active count exceeds 4, and 0 in the cycle after it is 4 or less. All other bits of redir_ctrl are always 0.
- R7: While reset is held, and until the first lookup after it, res_valid, res_queue, res_err and redir_ctrl are all 0.
- R8: A tc_count above 8 is treated as 8 active classes, both for writes and for the error check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write one entry of the shared indirection table |
| tbl_wr_idx | input | 6 | Entry index being written |
| tbl_wr_q | input | 5 | Local (in-class) queue number for that entry |
| tc_count | input | 4 | Number of active traffic classes |
| q_per_tc | input | 5 | Queues per class, used as the class offset stride |
| lk_valid | input | 1 | Lookup request strobe |
| lk_class | input | 3 | Traffic class of the packet |
| lk_hash | input | 32 | RSS hash of the packet |
| res_valid | output | 1 | Lookup result valid, one cycle after the request |
| res_queue | output | 5 | Final receive queue number |
| res_err | output | 1 | Lookup named an inactive class |
| redir_ctrl | output | 32 | Control word; bit 12 selects the secondary-table mode |

## Verification
The main function is checked in three phases, each followed by lookups. First, all eight classes are loaded with stride 4. This separates the per-class offsets from one another and from the shared value. Next, a reload with two classes and stride 8 shows that inactive class tables keep their old contents while active ones take the new offsets. The same phase shows that lookups to classes now out of range report an error. Lookups with random upper hash bits show that only the six low bits select the entry. A class count above eight, together with count changes on both sides of four, exercises the clamp and the select-bit timing.

// File: rtl/rssq_pkg.sv
package rssq_pkg;
  localparam int unsigned RSSQ_QW      = 5;
  localparam int unsigned RSSQ_IDX_W   = 6;
  localparam int unsigned RSSQ_NUM_TC  = 8;
  localparam int unsigned RSSQ_CW      = 4;
  localparam int unsigned RSSQ_CTRL_W  = 32;
  localparam int unsigned RSSQ_SEL_BIT = 12;
  localparam int unsigned RSSQ_WIDE_AT = 4;

  // queue = class offset plus local queue (caller truncates to queue width)
  function automatic int unsigned slot_value(input int unsigned cls,
                                             input int unsigned stride,
                                             input int unsigned local_q);
    return cls * stride + local_q;
  endfunction

  // requested class count limited to the number of class tables
  function automatic int unsigned clamp_count(input int unsigned req,
                                              input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

  function automatic logic wide_mode(input int unsigned active,
                                     input int unsigned limit);
    return active > limit;
  endfunction
endpackage

// File: rtl/rssq_class_table.sv
module rssq_class_table #(
  parameter int unsigned CLS   = 0,
  parameter int unsigned QW    = rssq_pkg::RSSQ_QW,
  parameter int unsigned IDX_W = rssq_pkg::RSSQ_IDX_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [QW-1:0]    wr_local,
  input  logic [QW-1:0]    stride,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [QW-1:0]    rd_q
);
  import rssq_pkg::*;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [QW-1:0] mem [DEPTH];
  logic [QW-1:0] wr_slot;

  assign wr_slot = QW'(slot_value(CLS, 32'(stride), 32'(wr_local)));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_slot;
  end

  assign rd_q = mem[rd_idx];
endmodule

// File: rtl/rssq_ctrl.sv
module rssq_ctrl #(
  parameter int unsigned CW      = rssq_pkg::RSSQ_CW,
  parameter int unsigned CTRL_W  = rssq_pkg::RSSQ_CTRL_W,
  parameter int unsigned SEL_BIT = rssq_pkg::RSSQ_SEL_BIT,
  parameter int unsigned WIDE_AT = rssq_pkg::RSSQ_WIDE_AT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     active_cnt,
  output logic [CTRL_W-1:0] ctrl_word
);
  import rssq_pkg::*;

  logic sel_q;
  logic live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      sel_q  <= wide_mode(32'(active_cnt), WIDE_AT);
      live_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[SEL_BIT] = sel_q;
  end

  // R6
  sel_follows_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (ctrl_word[SEL_BIT] == ($past(active_cnt) > CW'(WIDE_AT))));
endmodule

// File: rtl/rss_tc_redirector.sv
module rss_tc_redirector #(
  parameter int unsigned NUM_TC  = rssq_pkg::RSSQ_NUM_TC,
  parameter int unsigned QW      = rssq_pkg::RSSQ_QW,
  parameter int unsigned IDX_W   = rssq_pkg::RSSQ_IDX_W,
  parameter int unsigned HASH_W  = 32,
  parameter int unsigned CW      = rssq_pkg::RSSQ_CW,
  parameter int unsigned CTRL_W  = rssq_pkg::RSSQ_CTRL_W,
  parameter int unsigned SEL_BIT = rssq_pkg::RSSQ_SEL_BIT,
  parameter int unsigned WIDE_AT = rssq_pkg::RSSQ_WIDE_AT,
  localparam int unsigned CLS_W  = $clog2(NUM_TC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic [QW-1:0]     tbl_wr_q,
  input  logic [CW-1:0]     tc_count,
  input  logic [QW-1:0]     q_per_tc,
  input  logic              lk_valid,
  input  logic [CLS_W-1:0]  lk_class,
  input  logic [HASH_W-1:0] lk_hash,
  output logic              res_valid,
  output logic [QW-1:0]     res_queue,
  output logic              res_err,
  output logic [CTRL_W-1:0] redir_ctrl
);
  import rssq_pkg::*;

  logic [CW-1:0]    active_cnt;
  logic [NUM_TC-1:0] wr_vec;
  logic [IDX_W-1:0] rd_idx;
  logic [QW-1:0]    rd_q [NUM_TC];
  logic             class_ok;
  logic             live_q;
  logic             unused_hash_hi;

  assign active_cnt     = CW'(clamp_count(32'(tc_count), NUM_TC));
  assign rd_idx         = lk_hash[IDX_W-1:0];
  assign unused_hash_hi = ^lk_hash[HASH_W-1:IDX_W];
  assign class_ok       = 32'(lk_class) < 32'(active_cnt);

  for (genvar g = 0; g < NUM_TC; g++) begin : g_cls
    assign wr_vec[g] = tbl_wr_en && (32'(active_cnt) > g);
    rssq_class_table #(.CLS(g), .QW(QW), .IDX_W(IDX_W)) u_tbl (
      .clk      (clk),
      .wr_en    (wr_vec[g]),
      .wr_idx   (tbl_wr_idx),
      .wr_local (tbl_wr_q),
      .stride   (q_per_tc),
      .rd_idx   (rd_idx),
      .rd_q     (rd_q[g])
    );
  end

  rssq_ctrl #(.CW(CW), .CTRL_W(CTRL_W), .SEL_BIT(SEL_BIT), .WIDE_AT(WIDE_AT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_cnt (active_cnt),
    .ctrl_word  (redir_ctrl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_queue <= '0;
      res_err   <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      live_q    <= 1'b1;
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_err   <= !class_ok;
        res_queue <= class_ok ? rd_q[lk_class] : '0;
      end
    end
  end

  // R2
  fanout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |-> ($countones(wr_vec) == 32'(active_cnt)));

  // R4
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (res_valid == $past(lk_valid)));

  // R5
  err_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(lk_valid)) |-> (res_err == (32'($past(lk_class)) >= 32'($past(active_cnt)))));

  // R5
  err_zero_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_queue == '0));
endmodule

// File: tb/test_rss_tc_redirector.sv
module test_rss_tc_redirector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [5:0]  tbl_wr_idx = '0;
  logic [4:0]  tbl_wr_q = '0;
  logic [3:0]  tc_count = 4'd1;
  logic [4:0]  q_per_tc = 5'd1;
  logic        lk_valid = 1'b0;
  logic [2:0]  lk_class = '0;
  logic [31:0] lk_hash = '0;
  logic        res_valid;
  logic [4:0]  res_queue;
  logic        res_err;
  logic [31:0] redir_ctrl;

  int checks = 0;
  int errors = 0;
  int mdl [8][64];

  always #(CLK_PERIOD/2) clk = ~clk;

  rss_tc_redirector i_rss_tc_redirector (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_q(tbl_wr_q), .tc_count(tc_count), .q_per_tc(q_per_tc),
    .lk_valid(lk_valid), .lk_class(lk_class), .lk_hash(lk_hash),
    .res_valid(res_valid), .res_queue(res_queue), .res_err(res_err),
    .redir_ctrl(redir_ctrl)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_count(input int c);
    return (c > 8) ? 8 : c;
  endfunction

  // load the shared table; model keeps what every active class must hold
  task automatic fill(input int cnt, input int stride, input int base);
    @(negedge clk);
    tc_count = 4'(cnt);
    q_per_tc = 5'(stride);
    for (int i = 0; i < 64; i++) begin
      int v;
      v = (i + base) % stride;
      tbl_wr_en  = 1'b1;
      tbl_wr_idx = 6'(i);
      tbl_wr_q   = 5'(v);
      for (int c = 0; c < eff_count(cnt); c++) mdl[c][i] = (c * stride + v) % 32;
      @(negedge clk);
    end
    tbl_wr_en = 1'b0;
  endtask

  task automatic look(input string req, input int cls, input logic [31:0] hash);
    int exp_q;
    int exp_e;
    lk_valid = 1'b1;
    lk_class = 3'(cls);
    lk_hash  = hash;
    if (cls >= eff_count(int'(tc_count))) begin exp_q = 0; exp_e = 1; end
    else begin exp_q = mdl[cls][hash[5:0]]; exp_e = 0; end
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " valid"}, res_valid, 1);
    chk({req, " queue"}, res_queue, exp_q);
    chk({req, " err"}, res_err, exp_e);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R7 res_valid", res_valid, 0);
    chk("R7 res_queue", res_queue, 0);
    chk("R7 res_err", res_err, 0);
    chk("R7 redir_ctrl", redir_ctrl, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ctrl after reset", redir_ctrl, 0);
  endtask

  task automatic t_eight_classes;
    fill(8, 4, 1);
    chk("R6 select set", redir_ctrl, 32'h0000_1000);
    for (int c = 0; c < 8; c++) look("R1 eight classes", c, 32'(c * 9 + 2));
    look("R3 upper hash bits", 5, 32'hDEAD_BE00 | 32'd17);
    look("R3 same entry", 5, 32'd17);
    // R4: no request gives no valid
    @(negedge clk);
    chk("R4 idle valid", res_valid, 0);
    // R4: one cycle latency, output unchanged before the edge
    lk_valid = 1'b1; lk_class = 3'd3; lk_hash = 32'd40;
    #1 chk("R4 before edge", res_valid, 0);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R4 after edge valid", res_valid, 1);
    chk("R4 after edge queue", res_queue, mdl[3][40]);
  endtask

  task automatic t_two_classes;
    fill(2, 8, 3);
    chk("R6 select cleared", redir_ctrl, 0);
    look("R1 class0 stride8", 0, 32'd7);
    look("R1 class1 stride8", 1, 32'd60);
    look("R5 inactive class", 4, 32'd7);
    look("R5 inactive class7", 7, 32'hFFFF_FFFF);
    // R2: widen again without rewriting; class 5 keeps earlier contents
    @(negedge clk);
    tc_count = 4'd8; q_per_tc = 5'd4;
    #1 chk("R6 select not yet", redir_ctrl[12], 0);
    @(negedge clk);
    chk("R6 select one cycle later", redir_ctrl[12], 1);
    look("R2 untouched class5", 5, 32'd3);
    look("R2 rewritten class1", 1, 32'd3);
    @(negedge clk);
    tc_count = 4'd4;
    @(negedge clk);
    chk("R6 four classes", redir_ctrl, 0);
    tc_count = 4'd5;
    @(negedge clk);
    chk("R6 five classes", redir_ctrl, 32'h0000_1000);
  endtask

  task automatic t_clamp;
    fill(13, 3, 0);
    chk("R8 select on clamp", redir_ctrl, 32'h0000_1000);
    look("R8 class7 written", 7, 32'd22);
    look("R8 class6 written", 6, 32'h0000_0100 | 32'd63);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) for (int i = 0; i < 64; i++) mdl[c][i] = 0;
    t_reset();
    t_eight_classes();
    t_two_classes();
    t_clamp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule